// File: doc/BRIEF.md
# Deadline-Aware Octet Stream Merger

This block merges several simplex inbound octet streams into one outbound octet stream. The outbound stream moves at most one octet per clock, with ready/valid flow control. Every time the merger hands the outbound stream to a source, it first emits a two-octet header: the source's address octet (`ADDR_BASE + index`), then a `0x00` terminator. The source's data octets follow, unmodified. A receiver on the far side can therefore route every octet by tracking only these headers.

A burst stops in one of three ways. The first is the source's end-of-packet flag, in which case the whole packet has been sent. The second is a boundary strobe from the output side, such as the end of a 512-octet buffer; this splits the packet, and the receiver has to learn its length some other way. The third is a forced switch.

One input, the deadline input, must be served at least once every `DEADLINE_CYC` cycles. A saturating bucket counter measures that interval, and when it fills, it cuts the current burst so that the deadline input is served. Another input, the hot input, keeps a single burst open across its own packet ends while no other input has data, so it can fill the output at line rate. In all other cases, grants rotate round-robin.

Top module: `mux_stream_merge`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and every `in_ready` bit is 0.
- R2: Each burst begins with the address octet `ADDR_BASE + index` of the granted input, followed by `0x00`, before any data octet of that input.
- R3: At most one octet is accepted per cycle. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. Data octets of each input appear in their original order, with none lost.
- R4: After an octet with `in_last` set is accepted from a non-hot input, the burst ends, and the next accepted octet is a new header.
- R5: An `out_bound` strobe on an accepted data octet ends the burst after that octet. An `out_bound` strobe on a header octet is ignored, so a header is never split.
- R6: Without a forced switch, the next grant goes to the first input with valid data in ascending index order after the last granted input, wrapping around. After reset, index 0 is checked first.
- R7: Once `DEADLINE_CYC` cycles have passed since the deadline input's last grant (or since reset) and the deadline input has valid data, the active burst of any other input ends after its in-flight handshake. The deadline input is granted next.
- R8: The bucket counter restarts when the deadline input is granted, so the next forced switch comes no sooner than `DEADLINE_CYC` cycles later.
- R9: When the hot input is the only input with data, its burst continues across its own `in_last` with no new header, and with `out_ready` high it delivers one octet every cycle.
- R10: Only the granted input, and only during its data phase, sees `in_ready` high. `in_ready` then equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | N_IN*8 | Data octets, input i in bits [8i+7:8i] |
| in_valid | input | N_IN | Per-input valid |
| in_last | input | N_IN | Per-input end of packet, qualified by valid |
| in_ready | output | N_IN | Per-input ready |
| out_data | output | 8 | Outbound octet (header or data) |
| out_valid | output | 1 | Outbound valid |
| out_ready | input | 1 | Outbound ready |
| out_bound | input | 1 | Output-side boundary: the octet accepted now closes the current output buffer |

## Verification
The assertions assume that every input source follows ready/valid rules. A source raises valid without waiting for ready, and once valid is high it holds valid, data and last stable until the handshake. The stability check on the outbound port and the check that a forced switch goes to the deadline input both rely on this. The bench's source models change an input only in the cycle after its handshake, and they raise valid whenever a source is enabled.

// File: rtl/mux_stream_pkg.sv
package mux_stream_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_ADDR = 2'd1,
    MS_NUL  = 2'd2,
    MS_BODY = 2'd3
  } ms_state_e;

  localparam logic [7:0] HDR_TERM = 8'h00;

  // Address octet announcing input idx.
  function automatic logic [7:0] hdr_octet(input logic [7:0] base, input int unsigned idx);
    return base + idx[7:0];
  endfunction

endpackage

// File: rtl/ms_service_timer.sv
module ms_service_timer #(
  parameter int unsigned LIMIT = 48_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  // Saturating bucket: counts line-rate cycles since the last grant.
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/ms_grant_pick.sv
module ms_grant_pick #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned DL_IDX = 3,
  parameter int unsigned IW     = 2
) (
  input  logic [N_IN-1:0] req,
  input  logic [IW-1:0]   last,
  input  logic            expired,
  output logic            any,
  output logic            forced,
  output logic [IW-1:0]   idx
);
  // First requester after 'last', wrapping around.
  function automatic logic [IW-1:0] rr_next(input logic [N_IN-1:0] r, input logic [IW-1:0] l);
    logic [IW-1:0] pick;
    logic          found;
    pick  = l;
    found = 1'b0;
    for (int k = 1; k <= int'(N_IN); k++) begin
      int j;
      j = (int'(l) + k) % int'(N_IN);
      if (!found && r[j]) begin
        found = 1'b1;
        pick  = IW'(j);
      end
    end
    return pick;
  endfunction

  assign any    = |req;
  assign forced = expired && req[DL_IDX];
  assign idx    = forced ? IW'(DL_IDX) : rr_next(req, last);
endmodule

// File: rtl/mux_stream_merge.sv
module mux_stream_merge #(
  parameter int unsigned N_IN         = 4,
  parameter logic [7:0]  ADDR_BASE    = 8'h10,
  parameter int unsigned DEADLINE_CYC = 48_000_000,
  parameter int unsigned DL_IDX       = N_IN - 1,
  parameter int unsigned HOT_IDX      = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN*8-1:0] in_data,
  input  logic [N_IN-1:0]   in_valid,
  input  logic [N_IN-1:0]   in_last,
  output logic [N_IN-1:0]   in_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              out_bound
);
  import mux_stream_pkg::*;

  localparam int unsigned IW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam logic [IW-1:0] DL_SEL  = IW'(DL_IDX);
  localparam logic [IW-1:0] HOT_SEL = IW'(HOT_IDX);

  ms_state_e     state;
  logic [IW-1:0] sel;
  logic [IW-1:0] last_grant;

  // Named internal events, shared with the checker.
  logic          grant_evt;
  logic [IW-1:0] grant_idx;
  logic          pick_any;
  logic          pick_forced;
  logic          expired;
  logic          dl_restart;
  logic          body_fire;
  logic          src_valid;
  logic          src_last;
  logic          others_valid;
  logic          hot_hold;
  logic          force_sw;
  logic          force_cut;
  logic          burst_end;

  ms_grant_pick #(.N_IN(N_IN), .DL_IDX(DL_IDX), .IW(IW)) u_pick (
    .req(in_valid), .last(last_grant), .expired(expired),
    .any(pick_any), .forced(pick_forced), .idx(grant_idx)
  );

  ms_service_timer #(.LIMIT(DEADLINE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(dl_restart), .expired(expired)
  );

  assign grant_evt    = (state == MS_IDLE) && pick_any;
  assign dl_restart   = grant_evt && (grant_idx == DL_SEL);
  assign src_valid    = in_valid[sel];
  assign src_last     = in_last[sel];
  assign others_valid = |(in_valid & ~(N_IN'(1) << sel));
  assign hot_hold     = (sel == HOT_SEL) && !others_valid;
  assign body_fire    = (state == MS_BODY) && src_valid && out_ready;
  assign force_sw     = (state == MS_BODY) && expired && in_valid[DL_IDX] && (sel != DL_SEL);
  assign force_cut    = force_sw && (body_fire || !src_valid);
  assign burst_end    = force_cut ||
                        (body_fire && ((src_last && !hot_hold) || out_bound));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= MS_IDLE;
      sel        <= '0;
      last_grant <= IW'(N_IN - 1);
    end else begin
      unique case (state)
        MS_IDLE: if (grant_evt) begin
          sel        <= grant_idx;
          last_grant <= grant_idx;
          state      <= MS_ADDR;
        end
        MS_ADDR: if (out_ready) state <= MS_NUL;
        MS_NUL:  if (out_ready) state <= MS_BODY;
        MS_BODY: if (burst_end) state <= MS_IDLE;
        default: state <= MS_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      MS_ADDR: begin out_valid = 1'b1;      out_data = hdr_octet(ADDR_BASE, int'(sel)); end
      MS_NUL:  begin out_valid = 1'b1;      out_data = HDR_TERM; end
      MS_BODY: begin out_valid = src_valid; out_data = in_data[int'(sel)*8 +: 8]; end
      default: begin out_valid = 1'b0;      out_data = HDR_TERM; end
    endcase
  end

  for (genvar g = 0; g < int'(N_IN); g++) begin : g_ready
    assign in_ready[g] = (state == MS_BODY) && (sel == IW'(g)) && out_ready;
  end
endmodule

// File: rtl/ms_merge_chk.sv
module ms_merge_chk
  import mux_stream_pkg::*;
#(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned DL_IDX = 3,
  parameter int unsigned IW     = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            out_valid,
  input logic            out_ready,
  input logic [7:0]      out_data,
  input logic [N_IN-1:0] in_ready,
  input ms_state_e       st,
  input logic            grant_evt,
  input logic [IW-1:0]   grant_idx,
  input logic            force_cut,
  input logic            expired
);
  a_r10_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_ready) <= 1) && (!(|in_ready) || out_ready));

  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r2_grant_opens_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> (st == MS_ADDR) && out_valid);

  a_r2_nul_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MS_ADDR && out_ready) |=> (out_valid && out_data == 8'h00));

  a_r7_cut_serves_dl: assert property (@(posedge clk) disable iff (!rst_n)
    force_cut |=> (grant_evt && grant_idx == IW'(DL_IDX)));

  a_r8_bucket_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_evt && grant_idx == IW'(DL_IDX)) |=> !expired);

  a_r1_quiet_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MS_IDLE) |-> (!out_valid && in_ready == '0));
endmodule

bind mux_stream_merge ms_merge_chk #(.N_IN(N_IN), .DL_IDX(DL_IDX), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .in_ready(in_ready), .st(state), .grant_evt(grant_evt),
  .grant_idx(grant_idx), .force_cut(force_cut), .expired(expired)
);

// File: tb/sim_mux_stream_merge.sv
`timescale 1ns/1ps
module sim_mux_stream_merge;
  localparam int N = 4;
  localparam int D = 40;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*8-1:0] in_data = '0;
  logic [N-1:0]   in_valid = '0;
  logic [N-1:0]   in_last = '0;
  logic [N-1:0]   in_ready;
  logic [7:0]     out_data;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic           out_bound = 1'b0;

  always #2.5 clk = ~clk;

  mux_stream_merge #(.N_IN(N), .ADDR_BASE(8'h10), .DEADLINE_CYC(D), .DL_IDX(3), .HOT_IDX(0)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_bound(out_bound)
  );

  int n_chk = 0, n_fail = 0;
  bit src_en[N];
  int src_len[N];
  int src_cnt[N];
  int src_pos[N];
  bit fire[N];
  int rdy_mode, bnd_a, bnd_b;
  logic [7:0] log_d[0:1023];
  int log_c[0:1023];
  int log_n, cyc, r10_err;
  logic [7:0] hdr_v[0:255];
  int hdr_k[0:255];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Source models and output monitor.
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        fire[i] = in_valid[i] && in_ready[i];
        if (in_ready[i] && (!src_en[i] || !out_ready)) r10_err++;
      end
      if ($countones(in_ready) > 1) r10_err++;
      if (out_valid && out_ready && log_n < 1024) begin
        log_d[log_n] = out_data;
        log_c[log_n] = cyc;
        log_n++;
      end
    end else begin
      for (int i = 0; i < N; i++) fire[i] = 1'b0;
    end
    @(posedge clk);
    if (rst_n) cyc++;
    #1;
    for (int i = 0; i < N; i++) begin
      if (fire[i]) begin
        src_cnt[i]++;
        src_pos[i] = (src_len[i] != 0 && src_pos[i] == src_len[i] - 1) ? 0 : src_pos[i] + 1;
      end
      in_valid[i] = src_en[i];
      in_data[i*8 +: 8] = {2'(i), 1'b1, 5'(src_cnt[i])};
      in_last[i] = (src_len[i] != 0) && (src_pos[i] == src_len[i] - 1);
    end
    out_ready = (rdy_mode == 0) ? 1'b1 : cyc[0];
    out_bound = (log_n == bnd_a) || (log_n == bnd_b);
  end

  task automatic hold_reset();
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) begin
      src_en[i] = 1'b0; src_len[i] = 0; src_cnt[i] = 0; src_pos[i] = 0;
    end
    rdy_mode = 0; bnd_a = -1; bnd_b = -1;
    log_n = 0; cyc = 0; r10_err = 0;
  endtask

  task automatic release_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == '0, "R1", "in_ready in reset", int'(in_ready), 0);
    cyc = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Walks the log: headers must be addr then 0x00; data in order per source.
  task automatic parse(output int errs, output int nh);
    int cur, expn[N];
    bit want_nul;
    logic [7:0] d;
    errs = 0; nh = 0; cur = -1; want_nul = 0;
    for (int i = 0; i < N; i++) expn[i] = 0;
    for (int k = 0; k < log_n; k++) begin
      d = log_d[k];
      if (want_nul) begin
        if (d != 8'h00) errs++;
        want_nul = 0;
      end else if (d[7:2] == 6'b000100) begin
        if (nh < 256) begin hdr_v[nh] = d; hdr_k[nh] = k; end
        nh++;
        cur = int'(d[1:0]);
        want_nul = 1;
      end else if (cur < 0 || int'(d[7:6]) != cur || !d[5] || d[4:0] != 5'(expn[cur])) begin
        errs++;
      end else begin
        expn[cur]++;
      end
    end
  endtask

  task automatic t_single_packets();
    int e, nh;
    hold_reset();
    src_en[1] = 1; src_len[1] = 4;
    release_reset();
    run(20);
    parse(e, nh);
    chk(log_d[0] == 8'h11, "R2", "first addr", int'(log_d[0]), 'h11);
    chk(log_d[1] == 8'h00, "R2", "first NUL", int'(log_d[1]), 0);
    chk(log_d[6] == 8'h11 && log_d[7] == 8'h00, "R4", "header after EOP", int'(log_d[6]), 'h11);
    chk(e == 0, "R2", "stream parse errors", e, 0);
  endtask

  task automatic t_round_robin();
    int e, nh;
    hold_reset();
    for (int i = 0; i < 3; i++) begin src_en[i] = 1; src_len[i] = 2; end
    release_reset();
    run(40);
    parse(e, nh);
    chk(nh >= 6, "R6", "header count", nh, 6);
    for (int k = 0; k < 6; k++)
      chk(hdr_v[k] == 8'(8'h10 + k % 3), "R6", "grant order", int'(hdr_v[k]), 'h10 + k % 3);
  endtask

  task automatic t_backpressure();
    int e, nh;
    hold_reset();
    src_en[2] = 1; src_len[2] = 3; rdy_mode = 1;
    release_reset();
    run(60);
    parse(e, nh);
    chk(e == 0 && nh >= 3, "R3", "order under backpressure", e, 0);
    chk(r10_err == 0, "R10", "ready leaks", r10_err, 0);
  endtask

  task automatic t_out_boundary();
    int e, nh;
    hold_reset();
    src_en[1] = 1; src_len[1] = 0; bnd_a = 1; bnd_b = 4;
    release_reset();
    run(20);
    parse(e, nh);
    chk(log_d[2][5] == 1'b1, "R5", "bound on NUL ignored", int'(log_d[2]), 'h20);
    chk(log_d[5] == 8'h11 && log_d[6] == 8'h00, "R5", "burst split at bound", int'(log_d[5]), 'h11);
    chk(e == 0, "R5", "parse after split", e, 0);
  endtask

  task automatic t_hot_line_rate();
    int e, nh, gaps;
    hold_reset();
    src_en[0] = 1; src_len[0] = 4;
    release_reset();
    run(30);
    parse(e, nh);
    gaps = 0;
    for (int k = 1; k < log_n; k++) if (log_c[k] != log_c[k-1] + 1) gaps++;
    chk(nh == 1, "R9", "headers for solo hot", nh, 1);
    chk(gaps == 0 && log_n >= 25, "R9", "gaps", gaps, 0);
    chk(e == 0, "R9", "parse hot stream", e, 0);
  endtask

  task automatic t_deadline();
    int e, nh, c1, c2, found;
    hold_reset();
    src_en[0] = 1; src_len[0] = 0;
    src_en[3] = 1; src_len[3] = 2;
    release_reset();
    run(110);
    parse(e, nh);
    c1 = -1; c2 = -1; found = 0;
    for (int k = 0; k < nh && k < 256; k++)
      if (hdr_v[k] == 8'h13) begin
        if (found == 0) c1 = log_c[hdr_k[k]];
        else if (found == 1) c2 = log_c[hdr_k[k]];
        found++;
      end
    chk(hdr_v[0] == 8'h10, "R6", "first grant index 0", int'(hdr_v[0]), 'h10);
    chk(c1 >= D && c1 <= D + 5, "R7", "forced grant cycle", c1, D);
    chk(c2 - c1 >= D && c2 - c1 <= D + 6, "R8", "deadline restart gap", c2 - c1, D);
    chk(e == 0, "R7", "parse across cut", e, 0);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    hold_reset();
    t_single_packets();
    t_round_robin();
    t_backpressure();
    t_out_boundary();
    t_hot_line_rate();
    t_deadline();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule